// File: doc/BRIEF.md
# Debug Transport Test Access Port

This block is a test access port that carries debug traffic over the four-wire JTAG pins. It runs on a fast system clock and samples TCK as a level. Whenever it sees TCK go from low to high, it steps the 16-state TAP controller and shifts its instruction or data chains. TMS and TDI are used as they were at the sample before the edge, and the block drives TDO.

Three instructions are decoded, each selecting a chain of its own:

- an identification word (32 bits);
- a transport control word (32 bits) that reports the protocol version and the debug-bus address width;
- a debug-bus access chain of address width plus 34 bits.

Every other instruction code selects a one-bit bypass chain. The debug-bus access stage outside this block has two connections to it. It supplies the value that the bus chain captures. It receives each value shifted into that chain as a one-cycle strobe at Update-DR.

Top module: `dbg_tap`

## Requirements
- R1: The TAP state, the chains and TDO change only on a sampled low-to-high TCK transition. Toggling TMS or TDI without such an edge, or holding TCK at either level for many clock cycles, has no effect.
- R2: The controller follows the standard 16-state transition table indexed by TMS. Select-IR-Scan with TMS=1 goes to Test-Logic-Reset, and five edges with TMS=1 reach Test-Logic-Reset from any state.
- R3: After reset, and on every entry to Test-Logic-Reset or Capture-IR, the 5-bit instruction register holds 5'b00001. An IR scan therefore shifts out 00001, least significant bit first.
- R4: In Shift-DR and Shift-IR each edge shifts the active chain right, with TDI entering its top bit. On entering either shift state, TDO takes bit 0 of that chain, so chains leave least significant bit first.
- R5: Instruction 5'h01 selects the 32-bit identification chain, which captures parameter IDCODE. Instruction 5'h10 selects the 32-bit control chain. Instruction 5'h11 selects the debug-bus chain of ABITS+34 bits.
- R6: The control chain captures 1 in bits [3:0] (version) and ABITS in bits [9:4]. All other bits are zero, including bus status [11:10], idle hint [14:12] and bus reset [16].
- R7: At Capture-DR with the debug-bus instruction, the chain loads `dbus_cap`.
- R8: Any other instruction code selects a 1-bit bypass chain that captures 0. TDI then reappears on TDO one shift later.
- R9: On entry to Update-DR with the debug-bus instruction, `upd_valid` is high for exactly one clock and `upd_data` carries the whole shifted chain. No strobe occurs for any other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the JTAG pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| tck | input | 1 | Test clock, sampled as a level |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| dbus_cap | input | ABITS+34 | Value the debug-bus chain loads at Capture-DR |
| tdo | output | 1 | Test data out |
| upd_valid | output | 1 | One-cycle strobe on Update-DR with the bus instruction |
| upd_data | output | ABITS+34 | Chain value presented with the strobe |

## Verification
The bench exercises the chain length switch. It shifts identification, control, bus and bypass chains one after another and compares every captured bit. A design that kept one length, or inserted TDI at the wrong bit, would return shifted or truncated words. The bench stretches TCK levels and toggles TMS and TDI without an edge. A design that acted on levels rather than transitions would lose its place in the state table. The Select-IR exit and the five-ones reset are each followed by an identification read, which a design that failed to force the instruction register would not return. Strobe counts across all scans catch an update raised for the wrong instruction.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  localparam int IR_W = 5;

  localparam logic [IR_W-1:0] IR_IDENT  = 5'h01;
  localparam logic [IR_W-1:0] IR_XCTRL  = 5'h10;
  localparam logic [IR_W-1:0] IR_BUSACC = 5'h11;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {CH_IDENT, CH_CTRL, CH_BUS, CH_BYP} chain_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    tap_state_t n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dbg_tap_rstsync.sv
module dbg_tap_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/dbg_tap_edge.sv
module dbg_tap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  output logic rise,
  output logic tms_q,
  output logic tdi_q
);
  logic tck_s, tms_s, tdi_s, tck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_s <= 1'b0;
      tms_s <= 1'b0;
      tdi_s <= 1'b0;
      tck_q <= 1'b0;
      tms_q <= 1'b0;
      tdi_q <= 1'b0;
    end else begin
      tck_s <= tck;
      tms_s <= tms;
      tdi_s <= tdi;
      tck_q <= tck_s;
      tms_q <= tms_s;
      tdi_q <= tdi_s;
    end
  end

  assign rise = tck_s & ~tck_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R1
endmodule

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  input  logic       tms_q,
  output tap_state_t state,
  output tap_state_t state_d
);
  always_comb begin
    state_d = state;
    if (rise) state_d = tap_next(state, tms_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_d;
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(state)); // R1
  AST_SELIR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && tms_q && state == ST_SEL_IR) |=> state == ST_RESET); // R2
  AST_RESET_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && tms_q && state == ST_RESET) |=> state == ST_RESET); // R2
endmodule

// File: rtl/dbg_tap_chain.sv
module dbg_tap_chain
  import dbg_tap_pkg::*;
#(
  parameter int          ABITS  = 7,
  parameter logic [31:0] IDCODE = 32'h2C5A_E0F3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              tdi_q,
  input  tap_state_t        state,
  input  tap_state_t        state_d,
  input  logic [ABITS+33:0] dbus_cap,
  output logic              tdo,
  output logic              upd_valid,
  output logic [ABITS+33:0] upd_data
);
  localparam int          DW        = ABITS + 34;
  localparam int          WORD_W    = 32;
  localparam logic [31:0] CTRL_WORD = (32'(ABITS) << 4) | 32'd1;

  logic [IR_W-1:0] ir_q, ir_d, ir_sh;
  logic [DW-1:0]   dr_q, dr_d, dr_sh, upd_dat_q, upd_dat_d;
  logic            tdo_q, tdo_d, upd_v_q, upd_v_d;
  chain_t          sel;

  always_comb begin
    case (ir_q)
      IR_IDENT:  sel = CH_IDENT;
      IR_XCTRL:  sel = CH_CTRL;
      IR_BUSACC: sel = CH_BUS;
      default:   sel = CH_BYP;
    endcase
  end

  always_comb begin
    dr_sh = dr_q >> 1;
    case (sel)
      CH_BUS:  dr_sh[DW-1]     = tdi_q;
      CH_BYP:  dr_sh[0]        = tdi_q;
      default: dr_sh[WORD_W-1] = tdi_q;
    endcase
    ir_sh = {tdi_q, ir_q[IR_W-1:1]};
  end

  always_comb begin
    ir_d      = ir_q;
    dr_d      = dr_q;
    tdo_d     = tdo_q;
    upd_v_d   = 1'b0;
    upd_dat_d = upd_dat_q;
    if (rise) begin
      if (state == ST_SH_DR) dr_d = dr_sh;
      if (state == ST_SH_IR) ir_d = ir_sh;
      case (state_d)
        ST_RESET, ST_CAP_IR: ir_d = IR_IDENT;
        ST_CAP_DR: begin
          case (sel)
            CH_IDENT: dr_d = {{(DW-WORD_W){1'b0}}, IDCODE};
            CH_CTRL:  dr_d = {{(DW-WORD_W){1'b0}}, CTRL_WORD};
            CH_BUS:   dr_d = dbus_cap;
            default:  dr_d = '0;
          endcase
        end
        ST_SH_DR: tdo_d = dr_d[0];
        ST_SH_IR: tdo_d = ir_d[0];
        ST_UPD_DR: begin
          if (sel == CH_BUS) begin
            upd_v_d   = 1'b1;
            upd_dat_d = dr_d;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q      <= IR_IDENT;
      dr_q      <= '0;
      tdo_q     <= 1'b0;
      upd_v_q   <= 1'b0;
      upd_dat_q <= '0;
    end else begin
      ir_q      <= ir_d;
      dr_q      <= dr_d;
      tdo_q     <= tdo_d;
      upd_v_q   <= upd_v_d;
      upd_dat_q <= upd_dat_d;
    end
  end

  assign tdo       = tdo_q;
  assign upd_valid = upd_v_q;
  assign upd_data  = upd_dat_q;

  AST_IR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET || state == ST_CAP_IR) |-> ir_q == IR_IDENT); // R3
  AST_TDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(tdo_q)); // R1
  AST_BYP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAP_DR && sel == CH_BYP) |-> dr_q == '0); // R8
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_v_q |=> !upd_v_q); // R9
  AST_STROBE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    upd_v_q |-> (state == ST_UPD_DR && ir_q == IR_BUSACC)); // R9
endmodule

// File: rtl/dbg_tap.sv
module dbg_tap
  import dbg_tap_pkg::*;
#(
  parameter int          ABITS  = 7,
  parameter logic [31:0] IDCODE = 32'h2C5A_E0F3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic [ABITS+33:0] dbus_cap,
  output logic              tdo,
  output logic              upd_valid,
  output logic [ABITS+33:0] upd_data
);
  logic       rst_int_n, rise, tms_q, tdi_q;
  tap_state_t state, state_d;

  initial begin
    assert (ABITS >= 1 && ABITS <= 63); // R6
  end

  dbg_tap_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  dbg_tap_edge u_edge (
    .clk(clk), .rst_n(rst_int_n), .tck(tck), .tms(tms), .tdi(tdi),
    .rise(rise), .tms_q(tms_q), .tdi_q(tdi_q)
  );

  dbg_tap_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .rise(rise), .tms_q(tms_q),
    .state(state), .state_d(state_d)
  );

  dbg_tap_chain #(.ABITS(ABITS), .IDCODE(IDCODE)) u_chain (
    .clk(clk), .rst_n(rst_int_n), .rise(rise), .tdi_q(tdi_q),
    .state(state), .state_d(state_d), .dbus_cap(dbus_cap),
    .tdo(tdo), .upd_valid(upd_valid), .upd_data(upd_data)
  );
endmodule

// File: tb/dbg_tap_test.sv
module dbg_tap_test;
  localparam int          ABITS  = 7;
  localparam int          DW     = ABITS + 34;
  localparam logic [31:0] IDC    = 32'h2C5A_E0F3;
  localparam logic [31:0] CTRL_X = 32'h0000_0071;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [DW-1:0] dbus_cap = '0;
  logic          tdo, upd_valid;
  logic [DW-1:0] upd_data;

  int total = 0, bad = 0, strobes = 0;
  logic [DW-1:0] last_upd = '0;
  bit finished = 0;

  dbg_tap #(.ABITS(ABITS), .IDCODE(IDC)) uut (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
    .dbus_cap(dbus_cap), .tdo(tdo), .upd_valid(upd_valid), .upd_data(upd_data)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (upd_valid) begin
      strobes++;
      last_upd = upd_data;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tck_cycle(input logic m, input logic d, input int hold, output logic o);
    @(negedge clk);
    tms = m; tdi = d; tck = 1'b0;
    repeat (hold) @(negedge clk);
    tck = 1'b1;
    repeat (hold) @(negedge clk);
    o = tdo;
  endtask

  task automatic step(input logic m);
    logic o;
    tck_cycle(m, 1'b0, 3, o);
  endtask

  task automatic load_ir(input logic [4:0] code, output logic [4:0] q);
    logic o;
    step(1); step(1); step(0);
    tck_cycle(0, 1'b0, 3, o); q[0] = o;
    for (int i = 0; i < 5; i++) begin
      tck_cycle(i == 4, code[i], 3, o);
      if (i < 4) q[i+1] = o;
    end
    step(1); step(0);
  endtask

  task automatic scan_dr(input int len, input logic [63:0] din, input int hold,
                         output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1); step(0);
    tck_cycle(0, 1'b0, hold, o); dout[0] = o;
    for (int i = 0; i < len; i++) begin
      tck_cycle(i == len - 1, din[i], hold, o);
      if (i < len - 1) dout[i+1] = o;
    end
    step(1); step(0);
  endtask

  task automatic t_reset;
    logic [63:0] q;
    rst_n = 1'b0; tck = 1'b0; tms = 1'b1; tdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 tdo after reset", {63'b0, tdo}, 64'd0);
    chk("R9 no strobe after reset", {63'b0, upd_valid}, 64'd0);
    step(0);
    scan_dr(32, 64'h0, 3, q);
    chk("R5 ident chain selected after reset", q, {32'b0, IDC});
  endtask

  task automatic t_ir_capture;
    logic [4:0] q;
    load_ir(5'h10, q);
    chk("R3 IR capture value", {59'b0, q}, 64'd1);
    load_ir(5'h11, q);
    chk("R3 IR capture value again", {59'b0, q}, 64'd1);
  endtask

  task automatic t_ctrl;
    logic [4:0] q;
    logic [63:0] d;
    int s0;
    s0 = strobes;
    load_ir(5'h10, q);
    scan_dr(32, 64'hFFFF_FFFF, 3, d);
    chk("R6 control word", d, {32'b0, CTRL_X});
    chk("R9 no strobe for control", 64'(strobes - s0), 64'd0);
    scan_dr(32, 64'h0, 3, d);
    chk("R5 control recaptured", d, {32'b0, CTRL_X});
  endtask

  task automatic t_bus(input logic [DW-1:0] cap, input logic [DW-1:0] din);
    logic [4:0] q;
    logic [63:0] d;
    int s0;
    dbus_cap = cap;
    load_ir(5'h11, q);
    s0 = strobes;
    scan_dr(DW, {{(64-DW){1'b0}}, din}, 3, d);
    chk("R7 bus capture", d, {{(64-DW){1'b0}}, cap});
    chk("R9 one strobe for bus update", 64'(strobes - s0), 64'd1);
    chk("R4 bus update value", {{(64-DW){1'b0}}, last_upd}, {{(64-DW){1'b0}}, din});
  endtask

  task automatic t_bypass(input logic [4:0] code);
    logic [4:0] q;
    logic [63:0] d;
    int s0;
    load_ir(code, q);
    s0 = strobes;
    scan_dr(8, 64'hB4, 3, d);
    chk("R8 bypass delays by one", d, 64'h68);
    chk("R9 no strobe for bypass", 64'(strobes - s0), 64'd0);
  endtask

  task automatic t_ident_nostrobe;
    logic [4:0] q;
    logic [63:0] d;
    int s0;
    load_ir(5'h01, q);
    s0 = strobes;
    scan_dr(32, 64'h1234_5678, 3, d);
    chk("R5 ident by instruction", d, {32'b0, IDC});
    chk("R9 no strobe for ident", 64'(strobes - s0), 64'd0);
  endtask

  task automatic t_levels;
    logic [4:0] q;
    logic [63:0] d;
    logic o;
    load_ir(5'h10, q);
    step(1); step(0);
    tck_cycle(0, 1'b0, 3, o);
    chk("R4 tdo on entering shift", {63'b0, o}, 64'd1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); tms = i[0]; tdi = ~i[0];
    end
    tck = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); tms = ~i[0]; tdi = i[0];
    end
    chk("R1 no change without edge", {63'b0, tdo}, 64'd1);
    step(1); step(1); step(0);
    scan_dr(32, 64'h0, 12, d);
    chk("R1 slow tck still one step per edge", d, {32'b0, CTRL_X});
  endtask

  task automatic t_selir_reset;
    logic [4:0] q;
    logic [63:0] d;
    load_ir(5'h10, q);
    step(1); step(1); step(1);
    step(0);
    scan_dr(32, 64'h0, 3, d);
    chk("R2 Select-IR TMS=1 to reset", d, {32'b0, IDC});
  endtask

  task automatic t_five_ones;
    logic [4:0] q;
    logic [63:0] d;
    int s0;
    load_ir(5'h11, q);
    step(1); step(0); step(0);
    s0 = strobes;
    for (int i = 0; i < 5; i++) step(1);
    chk("R9 strobe passing Update-DR", 64'(strobes - s0), 64'd1);
    step(0);
    scan_dr(32, 64'h0, 3, d);
    chk("R2 five ones reach reset", d, {32'b0, IDC});
  endtask

  initial begin
    #(2_000_000ns);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ir_capture();
    t_ctrl();
    t_bus(41'h1A5_C3E1_7B2D, 41'h0F0_1234_5678);
    t_bus(41'h155_5555_5555, 41'h0AA_AAAA_AAA9);
    t_bypass(5'h1F);
    t_bypass(5'h00);
    t_ident_nostrobe();
    t_levels();
    t_selir_reset();
    t_five_ones();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule